// File: doc/BRIEF.md
# Multi-Channel Interrupt Aggregator

This block gathers interrupt events from a set of line channels and reduces them to one interrupt output. Each channel offers sixteen events, held in two 8-bit latched-status registers. Some events come from a live status level. For these, an edge-select bit chooses whether a rising edge or any change sets the latched bit. The other events are one-cycle pulses that set their latched bit directly. Every event has a mask bit, and one global mask can silence the output completely.

Software reads an 8-bit channel-summary register to see which channels hold unmasked pending events. It then reads that channel's latched registers. A read clears the register it returns. The output stays active until every channel has been acknowledged this way. A 2-bit pin-mode field sets the output as open-drain active low, push-pull active low or push-pull active high. The pad itself sits outside the block, so the block provides a drive value and an output enable.

Address map (byte registers):
- Channel c occupies addresses c*8 to c*8+7:
  - +0 and +1: latched bits 7:0 and 15:8.
  - +2 and +3: masks 7:0 and 15:8.
  - +4 and +5: edge selects 7:0 and 15:8.
  - +6 and +7: registered live status 7:0 and 15:8 (read only).
- 0x40: config. Bits 1:0 are the pin mode and bit 7 is the global mask.
- 0x41: channel summary (read only).
- Any other address reads 0.

By default, events 0 to 4 and 8 to 10 are level events and the rest are pulse events.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all latched, mask and edge-select bits are 0. The config register reads 0x80 (global mask 1, pin mode 00), the summary reads 0, and irq_oe is 0.
- R2: For a level event whose edge-select bit is 0, a 0-to-1 change of its status input sets the latched bit at the next clock edge. A 1-to-0 change does not set it.
- R3: For a level event whose edge-select bit is 1, both the 0-to-1 and the 1-to-0 change of its status input set the latched bit.
- R4: A pulse event sets its latched bit from a one-cycle pulse on evt_pulse. For such an event, the stat_level input and the edge-select bit have no effect.
- R5: A mask bit of 1 keeps its latched bit out of the summary and out of the output. The latched bit is still set and still reads back.
- R6: Summary bit n (address 0x41) is 1 exactly when channel n has a latched bit whose mask is 0. Bits above the channel count read 0. Reading the summary clears nothing.
- R7: Reading a latched register (offset +0 or +1) returns its bits and clears them at that clock edge. The channel's summary bit clears only when neither register has an unmasked bit left. The output turns inactive only after every channel has been cleared.
- R8: An event that arrives in the same cycle as a read-clear of its register wins, and its latched bit stays 1.
- R9: While the global mask (0x40 bit 7) is 1, the output is inactive whatever is pending. While it is 0, the output is active whenever the summary is nonzero.
- R10: Pin modes: 00 and 11 give open-drain active low (irq_out=0, irq_oe=active). 01 gives push-pull active low (irq_oe=1, irq_out=!active). 10 gives push-pull active high (irq_oe=1, irq_out=active).
- R11: Offsets +6 and +7 return the status inputs of the level events as registered one clock earlier. Pulse event positions read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_level | input | NUM_CH*16 | Live status per event, channel c at bits c*16+15:c*16 |
| evt_pulse | input | NUM_CH*16 | One-cycle event pulses, same layout |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe; clears latched registers on read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Interrupt drive value |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
The latching function is exercised with a rising level, a falling level, a level that toggles under any-edge selection, and one-cycle pulses in both register halves. Together these separate the level path from the pulse path and the two edge selections from each other. The clear path is exercised with pending events spread across two channels and both halves of one channel. It is also exercised with a pulse that coincides with a read, which shows whether the summary and the output follow the last acknowledgement and whether set wins over clear. Masked events, the global mask and all four pin codes, both with and without a pending event, separate gating from latching and polarity from drive enable.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int BYTE_W    = 8;
  localparam int EV_PER_CH = 2 * BYTE_W;

  typedef enum logic [1:0] {
    PIN_OD_LO  = 2'b00,
    PIN_PP_LO  = 2'b01,
    PIN_PP_HI  = 2'b10,
    PIN_OD_ALT = 2'b11
  } pin_mode_e;

  // Rising-only when any_edge is 0, every change otherwise.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic any_edge);
    return any_edge ? (cur ^ prev) : (cur & ~prev);
  endfunction

  // Returns {oe, out} for a pin mode and an active request.
  function automatic logic [1:0] pin_drive(input logic [1:0] mode, input logic act);
    case (mode)
      PIN_PP_LO: return {1'b1, ~act};
      PIN_PP_HI: return {1'b1, act};
      default:   return {act, 1'b0};
    endcase
  endfunction
endpackage

// File: rtl/irqa_chan.sv
module irqa_chan
  import irqa_pkg::*;
#(
  parameter logic [EV_PER_CH-1:0] LIVE_MAP = 16'h071F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EV_PER_CH-1:0] stat_in,
  input  logic [EV_PER_CH-1:0] pulse_in,
  input  logic                 wr_en,
  input  logic [2:0]           wr_off,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic                 clr_lo,
  input  logic                 clr_hi,
  output logic [EV_PER_CH-1:0] lat,
  output logic [EV_PER_CH-1:0] mask,
  output logic [EV_PER_CH-1:0] esel,
  output logic [EV_PER_CH-1:0] stat_q,
  output logic [EV_PER_CH-1:0] set_ev,
  output logic [EV_PER_CH-1:0] clr_ev,
  output logic                 pend
);
  localparam logic [2:0] OFF_MASK_LO = 3'd2;
  localparam logic [2:0] OFF_MASK_HI = 3'd3;
  localparam logic [2:0] OFF_ESEL_LO = 3'd4;
  localparam logic [2:0] OFF_ESEL_HI = 3'd5;

  for (genvar b = 0; b < EV_PER_CH; b++) begin : g_bit
    if (LIVE_MAP[b]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[b] <= 1'b0;
        else        stat_q[b] <= stat_in[b];
      end
      assign set_ev[b] = edge_hit(stat_in[b], stat_q[b], esel[b]);
    end else begin : g_pulse
      assign stat_q[b] = 1'b0;
      assign set_ev[b] = pulse_in[b];
    end
    if (b < BYTE_W) begin : g_lo
      assign clr_ev[b] = clr_lo;
    end else begin : g_hi
      assign clr_ev[b] = clr_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else        lat <= (lat & ~clr_ev) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      esel <= '0;
    end else if (wr_en) begin
      case (wr_off)
        OFF_MASK_LO: mask[BYTE_W-1:0]         <= wr_data;
        OFF_MASK_HI: mask[EV_PER_CH-1:BYTE_W] <= wr_data;
        OFF_ESEL_LO: esel[BYTE_W-1:0]         <= wr_data;
        OFF_ESEL_HI: esel[EV_PER_CH-1:BYTE_W] <= wr_data;
        default: ;
      endcase
    end
  end

  assign pend = |(lat & ~mask);
endmodule

// File: rtl/irqa_pin.sv
module irqa_pin
  import irqa_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       act,
  output logic       oe,
  output logic       out
);
  logic [1:0] drv;
  assign drv = pin_drive(mode, act);
  assign oe  = drv[1];
  assign out = drv[0];
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqa_pkg::*;
#(
  parameter int                    NUM_CH   = 4,
  parameter int                    SUM_W    = 8,
  parameter logic [EV_PER_CH-1:0]  LIVE_MAP = 16'h071F,
  parameter logic [7:0]            CFG_ADDR = 8'h40,
  parameter logic [7:0]            SUM_ADDR = 8'h41
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH*EV_PER_CH-1:0] stat_level,
  input  logic [NUM_CH*EV_PER_CH-1:0] evt_pulse,
  input  logic [7:0]                  reg_addr,
  input  logic                        reg_we,
  input  logic                        reg_re,
  input  logic [7:0]                  reg_wdata,
  output logic [7:0]                  reg_rdata,
  output logic                        irq_out,
  output logic                        irq_oe
);
  localparam int ALL_W = NUM_CH * EV_PER_CH;

  logic [1:0]       mode_q;
  logic             gmask_q;
  logic [SUM_W-1:0] summary;
  logic             irq_act;
  logic [ALL_W-1:0] lat_all, mask_all, esel_all, statq_all, set_all, clr_all;
  logic [NUM_CH-1:0] pend_vec;

  // Channel window: upper two address bits 0, channel index in bits 5:3.
  logic       in_chan;
  logic [2:0] ch_idx;
  logic [2:0] off;
  assign ch_idx  = reg_addr[5:3];
  assign off     = reg_addr[2:0];
  assign in_chan = (reg_addr[7:6] == 2'b00) && (int'(ch_idx) < NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = in_chan && (ch_idx == 3'(c));
    irqa_chan #(.LIVE_MAP(LIVE_MAP)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_in (stat_level[c*EV_PER_CH +: EV_PER_CH]),
      .pulse_in(evt_pulse[c*EV_PER_CH +: EV_PER_CH]),
      .wr_en   (reg_we && hit),
      .wr_off  (off),
      .wr_data (reg_wdata),
      .clr_lo  (reg_re && hit && off == 3'd0),
      .clr_hi  (reg_re && hit && off == 3'd1),
      .lat     (lat_all[c*EV_PER_CH +: EV_PER_CH]),
      .mask    (mask_all[c*EV_PER_CH +: EV_PER_CH]),
      .esel    (esel_all[c*EV_PER_CH +: EV_PER_CH]),
      .stat_q  (statq_all[c*EV_PER_CH +: EV_PER_CH]),
      .set_ev  (set_all[c*EV_PER_CH +: EV_PER_CH]),
      .clr_ev  (clr_all[c*EV_PER_CH +: EV_PER_CH]),
      .pend    (pend_vec[c])
    );
  end

  for (genvar s = 0; s < SUM_W; s++) begin : g_sum
    if (s < NUM_CH) begin : g_used
      assign summary[s] = pend_vec[s];
    end else begin : g_unused
      assign summary[s] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PIN_OD_LO;
      gmask_q <= 1'b1;
    end else if (reg_we && reg_addr == CFG_ADDR) begin
      mode_q  <= reg_wdata[1:0];
      gmask_q <= reg_wdata[7];
    end
  end

  assign irq_act = !gmask_q && (|summary);

  irqa_pin u_pin (
    .mode(mode_q),
    .act (irq_act),
    .oe  (irq_oe),
    .out (irq_out)
  );

  // Read path: pick a 16-bit channel vector, then its byte.
  function automatic logic [7:0] pick_byte(input logic [ALL_W-1:0] v, input logic [2:0] ch,
                                           input logic hi);
    logic [EV_PER_CH-1:0] w;
    w = v[int'(ch)*EV_PER_CH +: EV_PER_CH];
    return hi ? w[EV_PER_CH-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  always_comb begin
    reg_rdata = '0;
    if (in_chan) begin
      case (off[2:1])
        2'd0: reg_rdata = pick_byte(lat_all, ch_idx, off[0]);
        2'd1: reg_rdata = pick_byte(mask_all, ch_idx, off[0]);
        2'd2: reg_rdata = pick_byte(esel_all, ch_idx, off[0]);
        default: reg_rdata = pick_byte(statq_all, ch_idx, off[0]);
      endcase
    end else if (reg_addr == CFG_ADDR) begin
      reg_rdata = {gmask_q, 5'd0, mode_q};
    end else if (reg_addr == SUM_ADDR) begin
      reg_rdata = summary;
    end
  end
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk #(
  parameter int W     = 64,
  parameter int SUM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gmask_q,
  input logic             irq_act,
  input logic [SUM_W-1:0] summary,
  input logic [1:0]       mode_q,
  input logic             irq_oe,
  input logic             irq_out,
  input logic [W-1:0]     lat_all,
  input logic [W-1:0]     set_all,
  input logic [W-1:0]     clr_all
);
  // R8: a set event always leaves its bit at 1, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all != '0) |=> ((lat_all & $past(set_all)) == $past(set_all)));

  // R7: a cleared bit without a competing set drops to 0
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all != '0) |=> ((lat_all & $past(clr_all & ~set_all)) == '0));

  // R2: latched bits change only through a set or a clear
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((lat_all ^ $past(lat_all)) & ~$past(set_all | clr_all)) == '0));

  // R9: global mask keeps the output inactive
  p_gmask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_q |-> !irq_act);

  // R6: an active output needs a pending channel
  p_act_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_act |-> (summary != '0));

  // R10: open-drain mode never drives when idle and never drives high
  p_od_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00 || mode_q == 2'b11) |-> (!irq_out && (irq_oe == irq_act)));
endmodule

bind irq_aggregator irqa_chk #(.W(NUM_CH*16), .SUM_W(SUM_W)) u_irqa_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .gmask_q(gmask_q),
  .irq_act(irq_act),
  .summary(summary),
  .mode_q (mode_q),
  .irq_oe (irq_oe),
  .irq_out(irq_out),
  .lat_all(lat_all),
  .set_all(set_all),
  .clr_all(clr_all)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int CLK_P  = 10;
  localparam int NCH    = 4;
  localparam int AW     = NCH * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] stat_level = '0;
  logic [AW-1:0] evt_pulse = '0;
  logic [7:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic          reg_re = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          irq_out, irq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .stat_level(stat_level), .evt_pulse(evt_pulse),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out), .irq_oe(irq_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ch_addr(input int ch, input int offs);
    return 8'(ch * 8 + offs);
  endfunction

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input int ch, input int bitn);
    evt_pulse[ch*16 + bitn] = 1'b1;
    @(posedge clk); @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic set_stat(input int ch, input int bitn, input logic v);
    stat_level[ch*16 + bitn] = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    rd_check("R1 cfg", 8'h40, 8'h80);
    rd_check("R1 summary", 8'h41, 8'h00);
    rd_check("R1 latched", ch_addr(0, 0), 8'h00);
    rd_check("R1 mask", ch_addr(2, 3), 8'h00);
    rd_check("R1 esel", ch_addr(1, 4), 8'h00);
    check("R1 irq_oe", irq_oe, 1'b0);
    wr(8'h40, 8'h00);
  endtask

  task automatic t_rise;
    set_stat(0, 0, 1'b1);
    check("R2 oe after rise", irq_oe, 1'b1);
    check("R2 out after rise", irq_out, 1'b0);
    rd_check("R2 latched rise", ch_addr(0, 0), 8'h01);
    rd_check("R2 cleared", ch_addr(0, 0), 8'h00);
    check("R2 oe idle", irq_oe, 1'b0);
    set_stat(0, 0, 1'b0);
    rd_check("R2 fall ignored", ch_addr(0, 0), 8'h00);
  endtask

  task automatic t_any_edge;
    wr(ch_addr(0, 4), 8'h02);
    set_stat(0, 1, 1'b1);
    rd_check("R3 rise", ch_addr(0, 0), 8'h02);
    set_stat(0, 1, 1'b0);
    rd_check("R3 fall", ch_addr(0, 0), 8'h02);
    wr(ch_addr(0, 4), 8'h00);
  endtask

  task automatic t_pulse;
    wr(ch_addr(2, 4), 8'hE0);
    set_stat(2, 5, 1'b1);
    set_stat(2, 5, 1'b0);
    rd_check("R4 level ignored", ch_addr(2, 0), 8'h00);
    pulse(2, 5);
    rd_check("R4 pulse low", ch_addr(2, 0), 8'h20);
    pulse(2, 12);
    rd_check("R4 pulse high", ch_addr(2, 1), 8'h10);
    wr(ch_addr(2, 4), 8'h00);
  endtask

  task automatic t_mask;
    wr(ch_addr(3, 2), 8'h01);
    set_stat(3, 0, 1'b1);
    rd_check("R5 summary masked", 8'h41, 8'h00);
    check("R5 oe masked", irq_oe, 1'b0);
    rd_check("R5 still latched", ch_addr(3, 0), 8'h01);
    set_stat(3, 0, 1'b0);
    wr(ch_addr(3, 2), 8'h00);
  endtask

  task automatic t_clear;
    pulse(1, 5);
    pulse(1, 11);
    pulse(3, 6);
    rd_check("R6 summary two ch", 8'h41, 8'h0A);
    rd_check("R6 summary not cleared", 8'h41, 8'h0A);
    rd_check("R7 ch1 low", ch_addr(1, 0), 8'h20);
    rd_check("R7 ch1 high pending", 8'h41, 8'h0A);
    rd_check("R7 ch1 high", ch_addr(1, 1), 8'h08);
    rd_check("R7 ch1 gone", 8'h41, 8'h08);
    check("R7 still active", irq_oe, 1'b1);
    rd_check("R7 ch3", ch_addr(3, 0), 8'h40);
    rd_check("R7 all gone", 8'h41, 8'h00);
    check("R7 inactive", irq_oe, 1'b0);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    pulse(0, 6);
    reg_addr = ch_addr(0, 0); reg_re = 1'b1;
    evt_pulse[6] = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_re = 1'b0; evt_pulse = '0;
    check("R8 first read", d, 8'h40);
    rd_check("R8 survives clear", ch_addr(0, 0), 8'h40);
    rd_check("R8 then clear", ch_addr(0, 0), 8'h00);
  endtask

  task automatic t_gmask;
    pulse(0, 7);
    check("R9 active unmasked", irq_oe, 1'b1);
    wr(8'h40, 8'h80);
    check("R9 masked inactive", irq_oe, 1'b0);
    rd_check("R9 summary kept", 8'h41, 8'h01);
    wr(8'h40, 8'h00);
    check("R9 active again", irq_oe, 1'b1);
  endtask

  task automatic t_pins;
    wr(8'h40, 8'h01);
    check("R10 01 act", {irq_oe, irq_out}, 2'b10);
    wr(8'h40, 8'h02);
    check("R10 10 act", {irq_oe, irq_out}, 2'b11);
    wr(8'h40, 8'h03);
    check("R10 11 act", {irq_oe, irq_out}, 2'b10);
    rd_check("R10 clear", ch_addr(0, 0), 8'h80);
    check("R10 11 idle", {irq_oe, irq_out}, 2'b00);
    wr(8'h40, 8'h02);
    check("R10 10 idle", {irq_oe, irq_out}, 2'b10);
    wr(8'h40, 8'h01);
    check("R10 01 idle", {irq_oe, irq_out}, 2'b11);
    wr(8'h40, 8'h00);
    check("R10 00 idle", {irq_oe, irq_out}, 2'b00);
  endtask

  task automatic t_status;
    stat_level[16 + 0] = 1'b1;
    stat_level[16 + 9] = 1'b1;
    stat_level[16 + 6] = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_check("R11 status low", ch_addr(1, 6), 8'h01);
    rd_check("R11 status high", ch_addr(1, 7), 8'h02);
    rd_check("R11 clear low", ch_addr(1, 0), 8'h01);
    rd_check("R11 clear high", ch_addr(1, 1), 8'h02);
    stat_level = '0;
    @(posedge clk); @(negedge clk);
    rd_check("R11 status drop", ch_addr(1, 6), 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rise;
    t_any_edge;
    t_pulse;
    t_mask;
    t_clear;
    t_set_wins;
    t_gmask;
    t_pins;
    t_status;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule